// File: doc/BRIEF.md
# Comparator Change-Detect Interrupt Logic

This block sits between two analog comparators and the interrupt controller. It brings the asynchronous comparator outputs into the clock domain and applies a per-channel polarity control. It then compares the result against a snapshot that is taken every time software touches the control register. When the live value and the snapshot disagree, a sticky interrupt flag is raised. The mismatch is level-sensitive, so it keeps setting the flag until software reads or writes the control register, which refreshes the snapshot.

Software sees two byte-wide registers on a small strobe bus. The control register reports both conditioned comparator outputs and holds the polarity and pin-drive controls. The flag register holds the interrupt flag, which software can clear or set. The interrupt request is the flag qualified by three enable inputs: channel, peripheral group and global. The conditioned outputs can also be routed to two pin outputs.

Top module: `cmp_chg_irq`

## Requirements
- R1: After reset the flag, both polarity bits and the pin-drive bit are 0, the interrupt request is low and both pin outputs are 0.
- R2: When a synchronized comparator output differs from the snapshot, the flag reads 1 from the third rising edge after the input change. Synchronization takes two flops and the flag takes one more.
- R3: Address 0 is the control register. Bit 7 is channel 1's conditioned output, bit 6 is channel 0's, bits 1:0 are the polarity controls for channels 1:0, and bit 2 is pin drive. Address 1 holds the flag in bit 0. Unused bits read 0, and read data is 0 when no read strobe is present.
- R4: While a mismatch persists, writing 0 to the flag leaves it at 1. A mismatch has priority over a clearing write.
- R5: Any read or write of the control register loads the snapshot with the current conditioned outputs. After that, writing 0 to the flag clears it.
- R6: Writing 1 to flag bit 0 sets the flag even when no mismatch exists.
- R7: The interrupt request is high only when the flag and all three enables are 1. The flag still sets while any enable is 0.
- R8: A channel's polarity bit inverts its output before it is reported, compared and driven to a pin. A control write that changes polarity does not set the flag.
- R9: An output change that reaches the comparison in the same cycle as a control-register access is taken into the snapshot and does not set the flag.
- R10: After reset the snapshot follows the synchronized outputs until the synchronizer has filled. Inputs held high through reset therefore do not set the flag.
- R11: With pin drive at 1 the pin outputs follow the conditioned outputs (pin bit i = channel i). With pin drive at 0 they are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 2 | Raw asynchronous comparator outputs, bit i = channel i |
| bus_addr | input | ADDR_W (1) | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| en_cmp | input | 1 | Channel interrupt enable |
| en_periph | input | 1 | Peripheral-group interrupt enable |
| en_global | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |
| cmp_pin | output | 2 | Pin outputs of the conditioned comparator values |

## Verification
The hardest case is R9. A comparator change must reach the comparison in exactly the cycle in which the control register is read. The stimulus therefore changes the raw input and issues the read precisely two rising edges later, which is when the second synchronizer flop presents the new value. It then reads the flag to show that the change was absorbed. A second hard case is R10. Reset is applied with both inputs already high, and the flag is read only after the synchronizer has filled.

// File: rtl/cmp_chg_pkg.sv
package cmp_chg_pkg;

    localparam int NUM_CMP  = 2;
    localparam int REG_W    = 8;
    localparam int OUT_LSB  = 6;
    localparam int INV_LSB  = 0;
    localparam int OE_BIT   = 2;
    localparam int FLAG_BIT = 0;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_CTRL = 2'd1,
        RSEL_FLAG = 2'd2
    } rd_sel_e;

    typedef struct packed {
        logic    ctrl_acc;
        logic    ctrl_wr;
        logic    flag_wr;
        rd_sel_e rd_sel;
    } bus_dec_t;

endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/cmp_bus_dec.sv
module cmp_bus_dec
    import cmp_chg_pkg::*;
#(
    parameter int ADDR_W    = 1,
    parameter int CTRL_ADDR = 0,
    parameter int FLAG_ADDR = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output bus_dec_t          dec
);

    logic hit_ctrl, hit_flag;

    always_comb begin
        hit_ctrl     = (addr == ADDR_W'(CTRL_ADDR));
        hit_flag     = (addr == ADDR_W'(FLAG_ADDR));
        dec.ctrl_acc = hit_ctrl && (rd || wr);
        dec.ctrl_wr  = hit_ctrl && wr;
        dec.flag_wr  = hit_flag && wr;
        if (rd && hit_ctrl) begin
            dec.rd_sel = RSEL_CTRL;
        end else if (rd && hit_flag) begin
            dec.rd_sel = RSEL_FLAG;
        end else begin
            dec.rd_sel = RSEL_NONE;
        end
    end

endmodule

// File: rtl/cmp_out_gate.sv
module cmp_out_gate #(
    parameter int N = 2
) (
    input  logic         flag,
    input  logic         en_cmp,
    input  logic         en_periph,
    input  logic         en_global,
    input  logic         pin_oe,
    input  logic [N-1:0] cond_out,
    output logic         irq,
    output logic [N-1:0] pin
);

    assign irq = flag & en_cmp & en_periph & en_global;

    for (genvar g = 0; g < N; g++) begin : g_pin
        assign pin[g] = pin_oe & cond_out[g];
    end

endmodule

// File: rtl/cmp_chg_irq.sv
module cmp_chg_irq
    import cmp_chg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 1,
    parameter int CTRL_ADDR   = 0,
    parameter int FLAG_ADDR   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CMP-1:0] cmp_raw,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic               en_cmp,
    input  logic               en_periph,
    input  logic               en_global,
    output logic               irq,
    output logic [NUM_CMP-1:0] cmp_pin
);

    localparam int PRIME_LEN = SYNC_STAGES + 1;
    localparam int CNT_W     = $clog2(PRIME_LEN + 1);

    typedef struct packed {
        logic [NUM_CMP-1:0] inv;
        logic               oe;
        logic [NUM_CMP-1:0] snap;
        logic               flag;
        logic [CNT_W-1:0]   prime;
    } state_t;

    state_t             st_d, st_q;
    logic [NUM_CMP-1:0] sync_q;
    logic [NUM_CMP-1:0] cond_out;
    bus_dec_t           dec;
    logic               primed;
    logic               mismatch;
    logic               flag_w;
    logic               oe_w;
    logic [REG_W-1:0]   ctrl_view;
    logic [REG_W-1:0]   flag_view;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[REG_W-1:OE_BIT+1];

    cmp_sync #(
        .W      (NUM_CMP),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cmp_raw),
        .dout  (sync_q)
    );

    cmp_bus_dec #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .FLAG_ADDR (FLAG_ADDR)
    ) u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .dec  (dec)
    );

    // next-state computation
    always_comb begin
        cond_out = sync_q ^ st_q.inv;
        primed   = (st_q.prime == CNT_W'(PRIME_LEN));
        mismatch = primed && !dec.ctrl_acc && (cond_out != st_q.snap);

        st_d = st_q;

        if (!primed) begin
            st_d.prime = st_q.prime + 1'b1;
            st_d.snap  = cond_out;
        end

        if (dec.ctrl_wr) begin
            st_d.inv = bus_wdata[INV_LSB +: NUM_CMP];
            st_d.oe  = bus_wdata[OE_BIT];
        end

        if (dec.ctrl_acc) begin
            st_d.snap = sync_q ^ st_d.inv;
        end

        if (dec.flag_wr) begin
            st_d.flag = bus_wdata[FLAG_BIT];
        end

        if (mismatch) begin
            st_d.flag = 1'b1;
        end
    end

    // read data
    always_comb begin
        ctrl_view                       = '0;
        ctrl_view[OUT_LSB +: NUM_CMP]   = cond_out;
        ctrl_view[INV_LSB +: NUM_CMP]   = st_q.inv;
        ctrl_view[OE_BIT]               = st_q.oe;
        flag_view                       = '0;
        flag_view[FLAG_BIT]             = st_q.flag;
        case (dec.rd_sel)
            RSEL_CTRL: bus_rdata = ctrl_view;
            RSEL_FLAG: bus_rdata = flag_view;
            default:   bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_w = st_q.flag;
    assign oe_w   = st_q.oe;

    cmp_out_gate #(
        .N (NUM_CMP)
    ) u_gate (
        .flag      (flag_w),
        .en_cmp    (en_cmp),
        .en_periph (en_periph),
        .en_global (en_global),
        .pin_oe    (oe_w),
        .cond_out  (cond_out),
        .irq       (irq),
        .pin       (cmp_pin)
    );

endmodule

// File: rtl/cmp_chg_chk.sv
module cmp_chg_chk #(
    parameter int N = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         irq,
    input logic         en_cmp,
    input logic         en_periph,
    input logic         en_global,
    input logic [N-1:0] pin,
    input logic         flag,
    input logic         oe,
    input logic         mismatch,
    input logic         primed,
    input logic         ctrl_acc,
    input logic         flag_wr,
    input logic         wbit0
);

    AST_MISMATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch |=> flag); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_wr) |=> flag); // R4

    AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && wbit0) |=> flag); // R6

    AST_NO_IRQ_WO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> !irq); // R7

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (en_cmp && en_periph && en_global)); // R7

    AST_ACCESS_ABSORBS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_acc && !flag && !flag_wr) |=> !flag); // R9

    AST_PRIME_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!primed && !flag && !flag_wr) |=> !flag); // R10

    AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (pin == '0)); // R11

endmodule

bind cmp_chg_irq cmp_chg_chk #(.N(cmp_chg_pkg::NUM_CMP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .en_cmp    (en_cmp),
    .en_periph (en_periph),
    .en_global (en_global),
    .pin       (cmp_pin),
    .flag      (flag_w),
    .oe        (oe_w),
    .mismatch  (mismatch),
    .primed    (primed),
    .ctrl_acc  (dec.ctrl_acc),
    .flag_wr   (dec.flag_wr),
    .wbit0     (bus_wdata[0])
);

// File: tb/cmp_chg_irq_tb.sv
`timescale 1ns/1ps
module cmp_chg_irq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmp_raw = 2'b00;
    logic [0:0] bus_addr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       en_cmp = 1'b1;
    logic       en_periph = 1'b1;
    logic       en_global = 1'b1;
    logic       irq;
    logic [1:0] cmp_pin;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmp_chg_irq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_raw   (cmp_raw),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .en_cmp    (en_cmp),
        .en_periph (en_periph),
        .en_global (en_global),
        .irq       (irq),
        .cmp_pin   (cmp_pin)
    );

    typedef struct packed {
        logic [1:0] raw;
        logic       rd;
        logic       wr;
        logic       addr;
        logic [7:0] wdata;
        logic [2:0] en;     // {en_cmp, en_periph, en_global}
        logic [7:0] exp_rd;
        logic       exp_irq;
        logic [1:0] exp_pin;
        logic [3:0] req;
    } vec_t;

    // each row is one cycle; outputs are checked before that cycle's edge
    localparam vec_t VEC [0:30] = '{
        '{2'b00,1'b1,1'b0,1'b0,8'h00,3'b111,8'h00,1'b0,2'b00,4'd3},  // R3 ctrl after reset
        '{2'b00,1'b0,1'b1,1'b0,8'h04,3'b111,8'h00,1'b0,2'b00,4'd11}, // R11 pin drive on
        '{2'b11,1'b0,1'b0,1'b0,8'h00,3'b111,8'h00,1'b0,2'b00,4'd2},
        '{2'b11,1'b0,1'b0,1'b0,8'h00,3'b111,8'h00,1'b0,2'b00,4'd2},
        '{2'b11,1'b0,1'b0,1'b0,8'h00,3'b111,8'h00,1'b0,2'b11,4'd11},
        '{2'b11,1'b1,1'b0,1'b1,8'h00,3'b111,8'h01,1'b1,2'b11,4'd2},  // R2 flag up
        '{2'b11,1'b0,1'b1,1'b1,8'h00,3'b111,8'h00,1'b1,2'b11,4'd4},  // R4 clear blocked
        '{2'b11,1'b1,1'b0,1'b1,8'h00,3'b111,8'h01,1'b1,2'b11,4'd4},
        '{2'b11,1'b1,1'b0,1'b0,8'h00,3'b111,8'hC4,1'b1,2'b11,4'd5},  // R5 ctrl read
        '{2'b11,1'b0,1'b1,1'b1,8'h00,3'b111,8'h00,1'b1,2'b11,4'd5},
        '{2'b11,1'b1,1'b0,1'b1,8'h00,3'b111,8'h00,1'b0,2'b11,4'd5},  // R5 cleared
        '{2'b11,1'b0,1'b1,1'b1,8'h01,3'b111,8'h00,1'b0,2'b11,4'd6},  // R6 sw set
        '{2'b11,1'b1,1'b0,1'b1,8'h00,3'b111,8'h01,1'b1,2'b11,4'd6},
        '{2'b11,1'b0,1'b1,1'b1,8'h00,3'b111,8'h00,1'b1,2'b11,4'd6},
        '{2'b10,1'b0,1'b0,1'b0,8'h00,3'b110,8'h00,1'b0,2'b11,4'd7},
        '{2'b10,1'b0,1'b0,1'b0,8'h00,3'b110,8'h00,1'b0,2'b11,4'd7},
        '{2'b10,1'b0,1'b0,1'b0,8'h00,3'b110,8'h00,1'b0,2'b10,4'd7},
        '{2'b10,1'b1,1'b0,1'b1,8'h00,3'b110,8'h01,1'b0,2'b10,4'd7},  // R7 set, gated
        '{2'b10,1'b0,1'b0,1'b0,8'h00,3'b111,8'h00,1'b1,2'b10,4'd7},
        '{2'b10,1'b0,1'b0,1'b0,8'h00,3'b011,8'h00,1'b0,2'b10,4'd7},
        '{2'b10,1'b0,1'b1,1'b0,8'h05,3'b111,8'h00,1'b1,2'b10,4'd8},  // R8 invert ch0
        '{2'b10,1'b1,1'b0,1'b0,8'h00,3'b111,8'hC5,1'b1,2'b11,4'd8},
        '{2'b10,1'b0,1'b1,1'b1,8'h00,3'b111,8'h00,1'b1,2'b11,4'd8},
        '{2'b10,1'b1,1'b0,1'b1,8'h00,3'b111,8'h00,1'b0,2'b11,4'd8},
        '{2'b00,1'b0,1'b0,1'b0,8'h00,3'b111,8'h00,1'b0,2'b11,4'd9},
        '{2'b00,1'b0,1'b0,1'b0,8'h00,3'b111,8'h00,1'b0,2'b11,4'd9},
        '{2'b00,1'b1,1'b0,1'b0,8'h00,3'b111,8'h45,1'b0,2'b01,4'd9},  // R9 coincident read
        '{2'b00,1'b1,1'b0,1'b1,8'h00,3'b111,8'h00,1'b0,2'b01,4'd9},
        '{2'b00,1'b0,1'b0,1'b0,8'h00,3'b111,8'h00,1'b0,2'b01,4'd9},
        '{2'b00,1'b0,1'b1,1'b0,8'h01,3'b111,8'h00,1'b0,2'b01,4'd11}, // R11 pin drive off
        '{2'b00,1'b0,1'b0,1'b0,8'h00,3'b111,8'h00,1'b0,2'b00,4'd11}
    };

    task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", what, act, exp);
        end
    endtask

    task automatic idle();
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        bus_addr = 1'b0;
        bus_wdata = 8'h00;
    endtask

    // one bus read, checked before the edge
    task automatic rd_chk(input logic a, input logic [7:0] exp, input string what);
        @(negedge clk);
        bus_addr = a;
        bus_rd = 1'b1;
        bus_wr = 1'b0;
        #0.5;
        check(what, bus_rdata, exp);
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        bus_rd = 1'b0;
        @(negedge clk);
        idle();
    endtask

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);
        check("R1 pins after reset", {6'b0, cmp_pin}, 8'h00);
        check("R1 idle read data", bus_rdata, 8'h00);
        rd_chk(1'b1, 8'h00, "R1 flag after reset");

        // vector walk
        for (int i = 0; i < 31; i++) begin
            @(negedge clk);
            cmp_raw   = VEC[i].raw;
            bus_rd    = VEC[i].rd;
            bus_wr    = VEC[i].wr;
            bus_addr  = VEC[i].addr;
            bus_wdata = VEC[i].wdata;
            {en_cmp, en_periph, en_global} = VEC[i].en;
            #0.5;
            check($sformatf("R%0d vec %0d rdata", VEC[i].req, i), bus_rdata, VEC[i].exp_rd);
            check($sformatf("R%0d vec %0d irq", VEC[i].req, i), {7'b0, irq}, {7'b0, VEC[i].exp_irq});
            check($sformatf("R%0d vec %0d pins", VEC[i].req, i), {6'b0, cmp_pin}, {6'b0, VEC[i].exp_pin});
        end
        @(negedge clk);
        idle();
        {en_cmp, en_periph, en_global} = 3'b111;

        // R1 and R10: reset with flag set and both inputs high
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h07);
        @(negedge clk);
        cmp_raw = 2'b11;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 irq during reset", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R1 pins after reset with drive set", {6'b0, cmp_pin}, 8'h00);
        check("R10 irq after priming", {7'b0, irq}, 8'h00);
        rd_chk(1'b1, 8'h00, "R10 flag quiet with inputs high");
        rd_chk(1'b0, 8'hC0, "R10 ctrl shows synced inputs, R1 polarity cleared");

        // R2 exact latency: raw change, flag visible from third edge
        @(negedge clk);
        cmp_raw = 2'b01;
        repeat (2) @(negedge clk);
        bus_addr = 1'b1;
        bus_rd = 1'b1;
        #0.5;
        check("R2 flag not yet up after two edges", bus_rdata, 8'h00);
        @(negedge clk);
        #0.5;
        check("R2 flag up after third edge", bus_rdata, 8'h01);
        @(negedge clk);
        idle();

        // R3 no read strobe gives zero data
        bus_addr = 1'b1;
        #0.5;
        check("R3 no strobe read data", bus_rdata, 8'h00);
        idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule